// File: doc/BRIEF.md
# Write-Through Unified Cache Controller

This block is a unified instruction and data cache placed between a processor request port and an external memory port. It holds 8 KB as four ways of 64 sets, each line eight 32-bit words. Addresses are word addresses. A read that hits a valid line is answered from the cache with no memory traffic. A cachable read that misses fetches the whole line from memory, word 0 first through word 7, into a way picked by a free-running LFSR, and then returns the requested word. Reads flagged uncachable, and every access while the enable input is low, are done as a single memory access and leave the cache contents as they are. Writes always go to memory. A write that finds its line resident also updates the cached word, and a write miss allocates nothing.

The processor holds `req_valid` and its fields steady until `rsp_done` pulses for one cycle, and then drops `req_valid`. The memory side holds `mem_req`, address and data until `mem_ack` (or `mem_abort`) pulses for one cycle per word. The controller is a four-state machine. ST_IDLE looks up the held request. It goes to ST_DONE on an enabled cachable read hit, to ST_FILL on an enabled cachable read miss, and to ST_SINGLE in every other case. ST_SINGLE issues one beat and moves to ST_DONE on acknowledge or abort. ST_FILL issues eight beats, stepping only on acknowledge, and moves to ST_DONE after the eighth. ST_DONE pulses `rsp_done` and returns to ST_IDLE.

Top module: `ucache_top`

## Requirements
- R1: After reset, `mem_req` and `rsp_done` are low and the cache is disabled, so a cachable read takes exactly one memory beat.
- R2: Address bits [2:0] select the word in a line, bits [8:3] select one of 64 sets, and the upper bits form the tag. There are 4 ways of 8 words of 32 bits. Words of one line share bits [15:3].
- R3: An enabled cachable read that hits returns the cached word and makes no memory request.
- R4: An enabled cachable read miss issues exactly eight read beats at line offsets 0,1,...,7 in that order. The response comes after the eighth beat and carries the requested word.
- R5: A read with `req_cachable`=0 makes one read beat at the request address and does not fill the cache, so a later cachable read of that line still takes eight beats.
- R6: Every write makes exactly one write beat carrying the request address and data. A write miss allocates no line, so a later cachable read of that line takes eight beats and returns the written data.
- R7: A write to a resident line updates the cached word, so a later read hits with no beats and returns the new data.
- R8: While `cache_en`=0, every access is a single beat and the valid state is kept. After re-enabling, a line filled earlier hits again.
- R9: `mem_abort` during a line fill is ignored and the fill still completes with eight acknowledged beats and correct data. On a single access, an abort ends the access.
- R10: The victim way comes from a free-running LFSR, and a line just filled hits on the next read.
- R11: `mem_req` holds its address and direction until acknowledged or aborted, and `rsp_done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cache_en | input | 1 | Cache enable; when low every access bypasses |
| req_valid | input | 1 | Request held until rsp_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cachable | input | 1 | Access may use the cache |
| req_addr | input | WADDR_W | Word address |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with rsp_done |
| mem_req | output | 1 | Memory beat request |
| mem_write | output | 1 | Beat direction, 1 = write |
| mem_addr | output | WADDR_W | Beat word address |
| mem_wdata | output | DW | Beat write data |
| mem_ack | input | 1 | Beat acknowledge, carries mem_rdata |
| mem_abort | input | 1 | Beat abort response |
| mem_rdata | input | DW | Memory read data |

## Verification
Directed accesses are sorted by the number of memory beats each one produces and by the data it returns. Zero beats marks a hit, eight in order marks a fill, and one marks a bypass or a write. Each pattern separates one path from its neighbours. A cachable read first with the cache disabled and then enabled separates the reset enable state from the fill path. A repeated read separates a hit from a fill. An uncachable read followed by a cachable read, and a write miss followed by a read, show whether a line was allocated when it should not have been. A write followed by a read of a resident line shows whether the cached word was updated. Injected aborts during a fill and during a single read separate "abort ignored" from "abort ends the beat".

// File: rtl/ucache_pkg.sv
package ucache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_FILL   = 2'd2,
        ST_DONE   = 2'd3
    } ucache_state_t;
endpackage

// File: rtl/ucache_lfsr.sv
module ucache_lfsr #(
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [7:0] q_q;
    logic       fb;

    // maximal-length 8-bit polynomial x^8+x^6+x^5+x^4+1
    assign fb  = q_q[7] ^ q_q[5] ^ q_q[4] ^ q_q[3];
    assign rnd = q_q[OUT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 8'hA7;
        else        q_q <= {q_q[6:0], fb};
    end
endmodule

// File: rtl/ucache_tags.sv
module ucache_tags #(
    parameter int WAYS  = 4,
    parameter int SET_W = 6,
    parameter int TAG_W = 7,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SETS  = 1 << SET_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    input  logic             fill_en,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [SET_W-1:0] fill_set,
    input  logic [TAG_W-1:0] fill_tag
);
    logic [WAYS-1:0] match;

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vld_q <= '0;
            else if (fill_en && fill_way == WAY_W'(gw))
                vld_q[fill_set] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == WAY_W'(gw))
                tag_q[fill_set] <= fill_tag;
        end

        assign match[gw] = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) hit_way = WAY_W'(w);
    end

    assign hit = |match;
endmodule

// File: rtl/ucache_data.sv
module ucache_data #(
    parameter int WAYS  = 4,
    parameter int SET_W = 6,
    parameter int OFF_W = 3,
    parameter int DW    = 32,
    localparam int WAY_W = $clog2(WAYS),
    localparam int IDX_W = WAY_W + SET_W + OFF_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic [WAY_W-1:0] rd_way,
    input  logic [SET_W-1:0] rd_set,
    input  logic [OFF_W-1:0] rd_off,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [SET_W-1:0] wr_set,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [DW-1:0]    wr_data
);
    logic [DW-1:0] ram_q [DEPTH];

    assign rd_data = ram_q[{rd_way, rd_set, rd_off}];

    always_ff @(posedge clk) begin
        if (wr_en) ram_q[{wr_way, wr_set, wr_off}] <= wr_data;
    end
endmodule

// File: rtl/ucache_top.sv
module ucache_top
    import ucache_pkg::*;
#(
    parameter int WADDR_W = 16,
    parameter int DW      = 32,
    parameter int WAYS    = 4,
    parameter int SET_W   = 6,
    parameter int OFF_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cache_en,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_cachable,
    input  logic [WADDR_W-1:0] req_addr,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_done,
    output logic [DW-1:0]      rsp_rdata,
    output logic               mem_req,
    output logic               mem_write,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic               mem_ack,
    input  logic               mem_abort,
    input  logic [DW-1:0]      mem_rdata
);
    localparam int TAG_W = WADDR_W - SET_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);

    ucache_state_t    state_q, state_d;
    logic [OFF_W-1:0] beat_q;
    logic [WAY_W-1:0] way_q;
    logic [DW-1:0]    rdata_q;

    logic [OFF_W-1:0] r_off;
    logic [SET_W-1:0] r_set;
    logic [TAG_W-1:0] r_tag;
    logic             use_cache, tag_hit, beat_last, single_end;
    logic [WAY_W-1:0] hit_way, victim;
    logic [DW-1:0]    arr_rdata;
    logic             wr_en, fill_done;
    logic [WAY_W-1:0] wr_way;
    logic [OFF_W-1:0] wr_off;
    logic [DW-1:0]    wr_data;

    assign r_off      = req_addr[OFF_W-1:0];
    assign r_set      = req_addr[OFF_W +: SET_W];
    assign r_tag      = req_addr[WADDR_W-1 -: TAG_W];
    assign use_cache  = cache_en && req_cachable;
    assign beat_last  = &beat_q;
    assign single_end = mem_ack || mem_abort;

    ucache_lfsr #(.OUT_W(WAY_W)) u_rng (
        .clk(clk), .rst_n(rst_n), .rnd(victim)
    );

    ucache_tags #(.WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(r_set), .lk_tag(r_tag), .hit(tag_hit), .hit_way(hit_way),
        .fill_en(fill_done), .fill_way(way_q), .fill_set(r_set), .fill_tag(r_tag)
    );

    ucache_data #(.WAYS(WAYS), .SET_W(SET_W), .OFF_W(OFF_W), .DW(DW)) u_data (
        .clk(clk),
        .rd_way(hit_way), .rd_set(r_set), .rd_off(r_off), .rd_data(arr_rdata),
        .wr_en(wr_en), .wr_way(wr_way), .wr_set(r_set), .wr_off(wr_off),
        .wr_data(wr_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (req_valid) begin
                    if (!req_write && use_cache && tag_hit) state_d = ST_DONE;
                    else if (!req_write && use_cache)       state_d = ST_FILL;
                    else                                    state_d = ST_SINGLE;
                end
            ST_SINGLE: if (single_end)           state_d = ST_DONE;
            ST_FILL:   if (mem_ack && beat_last) state_d = ST_DONE;
            ST_DONE:                             state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            way_q   <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    beat_q <= '0;
                    way_q  <= victim;
                    if (req_valid && !req_write && use_cache && tag_hit)
                        rdata_q <= arr_rdata;
                end
                ST_SINGLE:
                    if (single_end && !req_write) rdata_q <= mem_rdata;
                ST_FILL:
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == r_off) rdata_q <= mem_rdata;
                    end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_write = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        rsp_done  = 1'b0;
        wr_en     = 1'b0;
        wr_way    = hit_way;
        wr_off    = r_off;
        wr_data   = req_wdata;
        fill_done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SINGLE: begin
                mem_req   = 1'b1;
                mem_write = req_write;
                wr_en     = single_end && req_write && tag_hit;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_addr  = {req_addr[WADDR_W-1:OFF_W], beat_q};
                wr_en     = mem_ack;
                wr_way    = way_q;
                wr_off    = beat_q;
                wr_data   = mem_rdata;
                fill_done = mem_ack && beat_last;
            end
            ST_DONE: rsp_done = 1'b1;
            default: ;
        endcase
    end

    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/ucache_chk.sv
module ucache_chk
    import ucache_pkg::*;
#(
    parameter int WADDR_W = 16,
    parameter int DW      = 32
) (
    input logic               clk,
    input logic               rst_n,
    input ucache_state_t      state_q,
    input logic               tag_hit,
    input logic               cache_en,
    input logic               req_valid,
    input logic               req_write,
    input logic               req_cachable,
    input logic [WADDR_W-1:0] req_addr,
    input logic [DW-1:0]      req_wdata,
    input logic               rsp_done,
    input logic               mem_req,
    input logic               mem_write,
    input logic [WADDR_W-1:0] mem_addr,
    input logic [DW-1:0]      mem_wdata,
    input logic               mem_ack,
    input logic               mem_abort
);
    logic start;
    assign start = (state_q == ST_IDLE) && req_valid;

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !req_write && cache_en && req_cachable && tag_hit) |=> (rsp_done && !mem_req)); // R3

    AST_FILL_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> (mem_req && !mem_write)); // R4

    AST_BYPASS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !req_write && !(cache_en && req_cachable)) |=>
        (mem_req && !mem_write && mem_addr == $past(req_addr))); // R5

    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req_write) |=> (mem_req && mem_write && mem_wdata == $past(req_wdata))); // R6

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_abort) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_write))); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R11
endmodule

bind ucache_top ucache_chk #(.WADDR_W(WADDR_W), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .tag_hit(tag_hit),
    .cache_en(cache_en), .req_valid(req_valid), .req_write(req_write),
    .req_cachable(req_cachable), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_abort(mem_abort)
);

// File: tb/ucache_top_bench.sv
`timescale 1ns/1ps
module ucache_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_cachable = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_write;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0, mem_abort = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_cmp = 0, n_bad = 0;
    int beat_cnt = 0;
    int alog_n = 0;
    logic [15:0] alog [16];
    logic [31:0] mem_m [int];
    logic inj_abort = 1'b0, ab_flag = 1'b0;

    always #10 clk = ~clk;

    ucache_top u_ucache_top (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .req_valid(req_valid), .req_write(req_write), .req_cachable(req_cachable),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_abort(mem_abort),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] pat(input logic [15:0] a);
        return {a ^ 16'hC3A5, a};
    endfunction

    function automatic logic [31:0] mread(input logic [15:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return pat(a);
    endfunction

    // memory model: one-cycle responses, optional abort before each ack
    always @(posedge clk) begin
        mem_ack   <= 1'b0;
        mem_abort <= 1'b0;
        if (rst_n && mem_req && !mem_ack && !mem_abort) begin
            if (inj_abort && !ab_flag) begin
                mem_abort <= 1'b1;
                ab_flag   <= 1'b1;
            end else begin
                mem_ack   <= 1'b1;
                ab_flag   <= 1'b0;
                mem_rdata <= mread(mem_addr);
                if (mem_write) mem_m[int'(mem_addr)] = mem_wdata;
                if (alog_n < 16) alog[alog_n] <= mem_addr;
                alog_n   <= alog_n + 1;
                beat_cnt <= beat_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic c, input logic [15:0] a,
                          input logic [31:0] d, output logic [31:0] q, output int nb);
        int base;
        @(negedge clk);
        base = beat_cnt;
        alog_n = 0;
        ab_flag = 1'b0;
        req_write = w; req_cachable = c; req_addr = a; req_wdata = d;
        req_valid = 1'b1;
        do begin
            @(posedge clk);
            #1;
        end while (!rsp_done);
        q = rsp_rdata;
        nb = beat_cnt - base;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] q; int nb;
        check(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 0);
        check(rsp_done == 1'b0, "R1 rsp_done after reset", 32'(rsp_done), 0);
        access(0, 1, 16'h0123, 0, q, nb);
        check(nb == 1, "R1 disabled at reset, beats", nb, 1);
        access(0, 1, 16'h0123, 0, q, nb);
        check(nb == 1 && q == pat(16'h0123), "R8 disabled repeat read single", nb, 1);
    endtask

    task automatic t_fill_hit();
        logic [31:0] q; int nb; bit ord;
        cache_en = 1'b1;
        access(0, 1, 16'h0123, 0, q, nb);
        check(nb == 8, "R4 miss fill beats", nb, 8);
        check(q == pat(16'h0123), "R4 fill returns requested word", q, pat(16'h0123));
        ord = 1;
        for (int i = 0; i < 8; i++)
            if (alog[i] != {13'h0024, 3'(i)}) ord = 0;
        check(ord, "R2 R4 fill order 0..7 within line", 32'(alog[0]), 32'h0120);
        access(0, 1, 16'h0125, 0, q, nb);
        check(nb == 0, "R3 hit makes no beat", nb, 0);
        check(q == pat(16'h0125), "R3 hit data", q, pat(16'h0125));
    endtask

    task automatic t_uncached();
        logic [31:0] q; int nb;
        access(0, 0, 16'h0448, 0, q, nb);
        check(nb == 1 && alog[0] == 16'h0448, "R5 uncachable single beat", nb, 1);
        check(q == pat(16'h0448), "R5 uncachable data", q, pat(16'h0448));
        access(0, 1, 16'h0448, 0, q, nb);
        check(nb == 8, "R5 line not filled by uncachable read", nb, 8);
    endtask

    task automatic t_write_miss();
        logic [31:0] q; int nb;
        access(1, 1, 16'h0812, 32'hDEAD0812, q, nb);
        check(nb == 1, "R6 write one beat", nb, 1);
        check(mread(16'h0812) == 32'hDEAD0812, "R6 memory written", mread(16'h0812), 32'hDEAD0812);
        access(0, 1, 16'h0812, 0, q, nb);
        check(nb == 8, "R6 write miss did not allocate", nb, 8);
        check(q == 32'hDEAD0812, "R6 read after write-through", q, 32'hDEAD0812);
    endtask

    task automatic t_write_hit();
        logic [31:0] q; int nb;
        access(1, 1, 16'h0125, 32'hBEEF0125, q, nb);
        check(nb == 1, "R6 write hit still goes to memory", nb, 1);
        check(mread(16'h0125) == 32'hBEEF0125, "R6 write hit memory", mread(16'h0125), 32'hBEEF0125);
        access(0, 1, 16'h0125, 0, q, nb);
        check(nb == 0 && q == 32'hBEEF0125, "R7 cached word updated", q, 32'hBEEF0125);
    endtask

    task automatic t_disable();
        logic [31:0] q; int nb;
        cache_en = 1'b0;
        access(0, 1, 16'h0121, 0, q, nb);
        check(nb == 1, "R8 disabled read single beat", nb, 1);
        cache_en = 1'b1;
        access(0, 1, 16'h0121, 0, q, nb);
        check(nb == 0 && q == pat(16'h0121), "R8 valid kept over disable", nb, 0);
    endtask

    task automatic t_abort();
        logic [31:0] q; int nb; bit ord;
        inj_abort = 1'b1;
        access(0, 1, 16'h0A07, 0, q, nb);
        check(nb == 8, "R9 fill ignores aborts", nb, 8);
        check(q == pat(16'h0A07), "R9 fill data despite aborts", q, pat(16'h0A07));
        ord = 1;
        for (int i = 0; i < 8; i++)
            if (alog[i] != {13'h0140, 3'(i)}) ord = 0;
        check(ord, "R9 fill order with aborts", 32'(alog[7]), 32'h0A07);
        access(0, 0, 16'h0B00, 0, q, nb);
        check(nb == 0, "R9 abort ends single access", nb, 0);
        inj_abort = 1'b0;
        access(0, 1, 16'h0A03, 0, q, nb);
        check(nb == 0 && q == pat(16'h0A03), "R9 aborted fill left valid line", nb, 0);
    endtask

    task automatic t_victim();
        logic [31:0] q; int nb;
        for (int k = 0; k < 6; k++) begin
            logic [15:0] a;
            a = 16'h0180 + 16'(k * 16'h0200) + 16'h0005;
            access(0, 1, a, 0, q, nb);
            check(nb == 8, "R10 new tag in shared set fills", nb, 8);
            access(0, 1, a, 0, q, nb);
            check(nb == 0 && q == pat(a), "R10 just-filled line hits", q, pat(a));
        end
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_uncached();
        t_write_miss();
        t_write_hit();
        t_disable();
        t_abort();
        t_victim();
        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule